// File: doc/BRIEF.md
# Cycle-Triggered Link Ownership Mux

This block decides who drives a group of outgoing serial-link lanes. After reset a management controller owns every lane, and the processing element that sits beside it is held in reset. Software loads a 64-bit target cycle through a small register port, in two 32-bit halves, and then sets a separate arm flag. From reset a free-running 64-bit counter advances once per clock. When the counter equals the target while the block is armed, every lane moves to the processing element, and that element's reset is released in the same cycle.

The handover happens only once per reset. The processing element keeps ownership even if the arm flag is cleared or the target is rewritten later. Because the target only counts once the block is armed, software can write the two halves in any order without a half-updated value triggering a premature switch. A status bit shows whether the handover has happened.

Top module: `link_owner_mux`

## Requirements
- R1: While reset is asserted and right after it, `lanes_o` equals `mu_lanes_i` on every lane, `pe_rst_no` is 0, and the registers at addresses 0, 1, 2 and 3 all read 0.
- R2: Register map on `addr_i`: address 0 holds target bits 31:0 and address 1 holds target bits 63:32 (both read/write). Address 2 bit 0 is the arm flag (read/write). Address 3 bit 0 is the switched status. A write takes effect at the clock edge where `req_i` and `we_i` are high. Reads are combinational from `addr_i`, and unused bits read 0.
- R3: The cycle counter is 0 in the first cycle after reset is released and goes up by one at each clock. The switch is taken at the edge where the counter equals the target and arm is 1. The outputs change in the next cycle, which is the cycle whose counter value is target+1.
- R4: While arm is 0 the block never switches, whatever the target and counter are.
- R5: The comparison covers all 64 bits, so a nonzero upper half prevents a match against the lower bits alone.
- R6: Before the switch `lanes_o` carries `mu_lanes_i` on all 7 lanes. After it, `lanes_o` carries `pe_lanes_i` on all 7 lanes.
- R7: `pe_rst_no` goes to 1 in the same cycle that the lanes move to the processing element.
- R8: The switch is sticky. Clearing arm or rewriting the target after the switch does not change the lanes, `pe_rst_no` or the status, until the next reset.
- R9: Arming after the counter has already passed the target does not cause a switch.
- R10: Writes to the status address (3) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| mu_lanes_i | input | 7x16 | Lane data from the management controller |
| pe_lanes_i | input | 7x16 | Lane data from the processing element |
| lanes_o | output | 7x16 | Lane data toward the elastic buffers |
| pe_rst_no | output | 1 | Active-low reset to the processing element |

## Verification
On every cycle the assertions check that the counter advances by exactly one, that a switch only appears after a cycle in which arm was set and the counter matched the target, that a disarmed block stays unswitched, that a switch never reverts, and that the lane source agrees with the state of `pe_rst_no`. Only the bench scenarios can show that the handover lands on exactly target+1 for a sweep of targets. The same holds for the cases that depend on history or on the whole register value: a target the counter has already passed, a nonzero upper half, rewrites after the switch, and ignored writes to the status register.

// File: rtl/lmux_pkg.sv
package lmux_pkg;
  localparam int unsigned BUS_W = 32;

  function automatic int unsigned halves(input int unsigned cnt_w);
    return (cnt_w + BUS_W - 1) / BUS_W;
  endfunction
endpackage

// File: rtl/lmux_regs.sv
module lmux_regs
  import lmux_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              switched_i,
  output logic [CNT_W-1:0]  target_o,
  output logic              arm_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned N_HALF   = halves(CNT_W);
  localparam int unsigned ARM_ADDR = N_HALF;
  localparam int unsigned STS_ADDR = N_HALF + 1;

  logic [N_HALF-1:0][BUS_W-1:0] half_q;
  logic                          arm_q;
  logic                          wr;

  assign wr = req_i && we_i;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) half_q[h] <= '0;
      else if (wr && addr_i == ADDR_W'(h)) half_q[h] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else if (wr && addr_i == ADDR_W'(ARM_ADDR)) arm_q <= wdata_i[0];
  end

  assign target_o = CNT_W'(half_q);
  assign arm_o    = arm_q;

  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < N_HALF; h++)
      if (addr_i == ADDR_W'(h)) rdata_o = half_q[h];
    if (addr_i == ADDR_W'(ARM_ADDR)) rdata_o = BUS_W'(arm_q);
    if (addr_i == ADDR_W'(STS_ADDR)) rdata_o = BUS_W'(switched_i);
  end

  assert_arm_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(ARM_ADDR)) |=> arm_q == $past(wdata_i[0]));
endmodule

// File: rtl/lmux_trigger.sv
module lmux_trigger #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             switched_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             switched_q;
  logic             fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  // one-way: once set, only reset clears it
  assign fire = arm_i && (cnt_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   switched_q <= 1'b0;
    else if (fire) switched_q <= 1'b1;
  end

  assign switched_o = switched_q;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_fire_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(switched_q) |-> $past(arm_i && cnt_q == target_i));
  assert_disarmed_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !switched_q) |=> !switched_q);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switched_q |=> switched_q);
endmodule

// File: rtl/lmux_lanes.sv
module lmux_lanes #(
  parameter int unsigned N_LINKS = 7,
  parameter int unsigned LANE_W  = 16
) (
  input  logic                           sel_pe_i,
  input  logic [N_LINKS-1:0][LANE_W-1:0] mu_i,
  input  logic [N_LINKS-1:0][LANE_W-1:0] pe_i,
  output logic [N_LINKS-1:0][LANE_W-1:0] lanes_o
);
  for (genvar l = 0; l < N_LINKS; l++) begin : g_lane
    assign lanes_o[l] = sel_pe_i ? pe_i[l] : mu_i[l];
  end
endmodule

// File: rtl/link_owner_mux.sv
module link_owner_mux
  import lmux_pkg::*;
#(
  parameter int unsigned N_LINKS = 7,
  parameter int unsigned LANE_W  = 16,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned ADDR_W  = $clog2(halves(CNT_W) + 2)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic [N_LINKS-1:0][LANE_W-1:0] mu_lanes_i,
  input  logic [N_LINKS-1:0][LANE_W-1:0] pe_lanes_i,
  output logic [N_LINKS-1:0][LANE_W-1:0] lanes_o,
  output logic                           pe_rst_no
);
  logic [CNT_W-1:0] target;
  logic             arm;
  logic             switched;

  lmux_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .switched_i(switched), .target_o(target), .arm_o(arm), .rdata_o
  );

  lmux_trigger #(.CNT_W(CNT_W)) i_trigger (
    .clk_i, .rst_ni, .arm_i(arm), .target_i(target), .switched_o(switched)
  );

  lmux_lanes #(.N_LINKS(N_LINKS), .LANE_W(LANE_W)) i_lanes (
    .sel_pe_i(switched), .mu_i(mu_lanes_i), .pe_i(pe_lanes_i), .lanes_o
  );

  assign pe_rst_no = switched;

  assert_rst_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_rst_no |-> lanes_o == pe_lanes_i);
  assert_mu_owned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_rst_no |-> lanes_o == mu_lanes_i);
endmodule

// File: tb/test_link_owner_mux.sv
module test_link_owner_mux;
  localparam int NL = 7;
  localparam int LW = 16;
  localparam int LV = NL * LW;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0, we_i = 1'b0;
  logic [1:0]       addr_i = '0;
  logic [31:0]      wdata_i = '0;
  logic [31:0]      rdata_o;
  logic [NL-1:0][LW-1:0] mu_lanes_i, pe_lanes_i, lanes_o;
  logic             pe_rst_no;

  int errors = 0, checks = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  link_owner_mux i_link_owner_mux (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .mu_lanes_i, .pe_lanes_i, .lanes_o, .pe_rst_no
  );

  function automatic logic [LV-1:0] pat(input int s);
    logic [LV-1:0] v;
    for (int i = 0; i < NL; i++) v[i*LW +: LW] = LW'(s * 37 + i * 4099 + 'h1234);
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one clock edge per write; returns at a negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr_i = a; #1;
    check(req, 128'(rdata_o), 128'(exp));
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  task automatic check_owner(input string req, input bit sw);
    check(req, 128'(pe_rst_no), 128'(sw));
    check(req, 128'(lanes_o), sw ? 128'(pe_lanes_i) : 128'(mu_lanes_i));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mu_lanes_i = pat(1); pe_lanes_i = pat(1001);
    // R1 reset state
    @(negedge clk_i); #1;
    check_owner("R1 in reset", 1'b0);
    do_reset();
    check_owner("R1 after reset", 1'b0);
    for (int a = 0; a < 4; a++) rd("R1 regs zero", 2'(a), 32'h0);

    // R2 readback, R10 status write ignored
    wr(2'd0, 32'hdead_beef); wr(2'd1, 32'h1234_5678); wr(2'd3, 32'hffff_ffff);
    rd("R2 target lo", 2'd0, 32'hdead_beef);
    rd("R2 target hi", 2'd1, 32'h1234_5678);
    rd("R10 status write ignored", 2'd3, 32'h0);
    wr(2'd2, 32'hffff_ffff); rd("R2 arm bit0 only", 2'd2, 32'h1);
    wr(2'd2, 32'h0);         rd("R2 arm cleared", 2'd2, 32'h0);

    // R4 disarmed: counter passes target, no switch
    do_reset();
    wr(2'd0, 32'd30); wr(2'd1, 32'd0);
    wait_cyc(40);
    check_owner("R4 disarmed", 1'b0);
    rd("R4 status", 2'd3, 32'h0);

    // R3/R6/R7 sweep of targets, exact switch cycle
    for (int t = 20; t < 28; t++) begin
      mu_lanes_i = pat(t); pe_lanes_i = pat(t * 7 + 500);
      do_reset();
      wr(2'd1, 32'd0); wr(2'd0, 32'(t)); wr(2'd2, 32'd1);
      wait_cyc(t - 2);
      for (int k = 0; k < 6; k++) begin
        check_owner("R3 R6 R7 sweep", cyc > t);
        rd("R3 status", 2'd3, 32'(cyc > t));
        @(negedge clk_i);
      end
    end

    // R5 upper half nonzero blocks low-half match
    do_reset();
    wr(2'd0, 32'd10); wr(2'd1, 32'd1); wr(2'd2, 32'd1);
    wait_cyc(20);
    check_owner("R5 upper half", 1'b0);
    rd("R5 status", 2'd3, 32'h0);

    // R9 arming after target passed
    do_reset();
    wr(2'd0, 32'd5);
    wait_cyc(10);
    wr(2'd2, 32'd1);
    wait_cyc(25);
    check_owner("R9 late arm", 1'b0);

    // R8 sticky after switch, R10 status write ignored after switch
    do_reset();
    mu_lanes_i = pat(77); pe_lanes_i = pat(88);
    wr(2'd0, 32'd12); wr(2'd2, 32'd1);
    wait_cyc(15);
    check_owner("R8 switched", 1'b1);
    wr(2'd2, 32'd0); wr(2'd0, 32'd200); wr(2'd3, 32'd0);
    rd("R8 arm reads 0", 2'd2, 32'h0);
    rd("R8 status sticky", 2'd3, 32'h1);
    mu_lanes_i = pat(99); pe_lanes_i = pat(111);
    wait_cyc(210);
    check_owner("R8 still pe", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule